// File: doc/BRIEF.md
# South-Bridge Configuration Register File

This block holds the byte-wide configuration space of a two-function south-bridge model. Function 0 is general bridge control. Function 1 is the IDE controller. A single request port carries a function number, an 8-bit offset and, for writes, a data byte. Writes are not plain stores. Each implemented byte applies its own write mask. Identification bytes are write-protected. Some bit positions are forced to fixed values.

Several outputs come straight from the stored bytes. Two pins enable the primary and secondary IDE channels. A 16-address I/O window for the bus-master engine has a relocatable base, and the block compares an I/O address against it to raise a hit flag. A parameter selects an early or a late chip generation. The generations differ in how one function-0 byte is masked and in whether one extra function-1 byte exists.

The request port uses valid/ready. `req_ready` is tied high, so the block never applies back-pressure. A request is accepted on every clock edge where `req_valid` is high. A write takes effect at that edge. A read returns its byte on `rd_data` combinationally, in the same cycle as the request.

Top module: `cfgsp_top`

## Requirements
- R1: Writes with a function number of 2 or more change no stored byte and no output. Reads with such a function number return 0x00.
- R2: A function-1 write to offset 0x04 updates only bits 0 and 2. Bits 7:3 and bit 1 keep their previous values.
- R3: A function-1 write to offset 0x07 updates only bits 5:3. All other bits keep their previous values.
- R4: A function-1 write to offset 0x20 stores data bits 7:4, and bits 3:0 become 4'b0001. After reset this byte reads 0x01.
- R5: Function-1 offsets 0x0D, 0x21, 0x40 and 0x42 store all eight written bits.
- R6: `pri_en` equals bit 7 of function-1 offset 0x41, and `sec_en` equals bit 7 of offset 0x43. Each changes only in the cycle after a write to its own byte.
- R7: `io_hit` is high when bit 0 of function-1 offset 0x04 is set and `io_addr[15:4]` equals {offset 0x21, offset 0x20 bits 7:4}. The window therefore spans 16 addresses, and moving the base moves the window at once.
- R8: Function-0 offsets 0x00 to 0x03, 0x08 to 0x0B and 0x0E ignore writes. They read vendor 0x1D0C (offset 0 = 0x0C, offset 1 = 0x1D), device 0x0A10, revision 0x02, class bytes 0x00, 0x01, 0x06 and header 0x80. All other function-0 offsets store the full byte.
- R9: Function-1 offset 0x44 is fully writable when LATE_GEN=1. When LATE_GEN=0 it ignores writes and reads 0x00.
- R10: On a function-0 write to offset 0x6A, the data byte is stored with some bits held at 1: bit 1 when LATE_GEN=1, and bits 1:0 when LATE_GEN=0. The held bits are also set at reset.
- R11: After reset, every writable byte reads 0x00 except the forced bits of R4 and R10. Function-1 offsets 0x00 to 0x03 read vendor 0x1D0C and device 0x0A11. Unimplemented function-1 offsets read 0x00 and ignore writes.
- R12: `req_ready` is always high. `rd_data` reflects the addressed byte in the same cycle as the request, including writes committed at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (constant high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_func | input | 3 | Function number |
| req_addr | input | 8 | Register offset |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current request |
| io_addr | input | 16 | I/O address to test against the bus-master window |
| io_hit | output | 1 | io_addr lies in the enabled bus-master window |
| pri_en | output | 1 | Primary IDE channel enable |
| sec_en | output | 1 | Secondary IDE channel enable |

## Verification
The bench builds two copies side by side from one stimulus stream: one with LATE_GEN=1 and one with LATE_GEN=0. Comparing each copy against its own expected value reaches both maskings of offset 0x6A. It also shows that offset 0x44 is present in one generation and absent in the other. Every other byte and pin must agree between the two copies, which confirms that the parameter touches nothing else.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  localparam int FUNC_W   = 3;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int IO_W     = 16;
  localparam int WIN_BITS = 4;
  localparam int F0_DEPTH = 1 << ADDR_W;

  localparam logic [15:0] VENDOR_ID = 16'h1D0C;
  localparam logic [15:0] DEV_F0    = 16'h0A10;
  localparam logic [15:0] DEV_F1    = 16'h0A11;
  localparam logic [7:0]  F0_REV    = 8'h02;
  localparam logic [7:0]  F0_HDR    = 8'h80;
  localparam logic [7:0]  F0_CLS0   = 8'h00;
  localparam logic [7:0]  F0_CLS1   = 8'h01;
  localparam logic [7:0]  F0_CLS2   = 8'h06;

  localparam logic [ADDR_W-1:0] OFS_MASKED6A = 8'h6A;

  // offsets in function 0 that ignore writes
  function automatic logic f0_is_ro(input logic [ADDR_W-1:0] a);
    return (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || (a == 8'h0E);
  endfunction

  // identification bytes of function 0, zero elsewhere
  function automatic logic [DATA_W-1:0] f0_reset_byte(input logic [ADDR_W-1:0] a);
    case (a)
      8'h00:   return VENDOR_ID[7:0];
      8'h01:   return VENDOR_ID[15:8];
      8'h02:   return DEV_F0[7:0];
      8'h03:   return DEV_F0[15:8];
      8'h08:   return F0_REV;
      8'h09:   return F0_CLS0;
      8'h0A:   return F0_CLS1;
      8'h0B:   return F0_CLS2;
      8'h0E:   return F0_HDR;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfgsp_f0_regs.sv
module cfgsp_f0_regs
  import cfgsp_pkg::*;
#(
  parameter bit LATE_GEN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] HOLD_MASK = LATE_GEN ? 8'h02 : 8'h03;

  logic [DATA_W-1:0] bytes_q [F0_DEPTH];
  logic [DATA_W-1:0] wr_val;

  always_comb begin
    wr_val = wdata;
    if (addr == OFS_MASKED6A) wr_val = wdata | HOLD_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < F0_DEPTH; i++)
        bytes_q[i] <= f0_reset_byte(ADDR_W'(i)) |
                      ((ADDR_W'(i) == OFS_MASKED6A) ? HOLD_MASK : '0);
    end else if (we && !f0_is_ro(addr)) begin
      bytes_q[addr] <= wr_val;
    end
  end

  assign rdata = bytes_q[addr];

  // protected identification bytes survive a write
  assert_ro_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && f0_is_ro(addr)) |=> (bytes_q[$past(addr)] == $past(bytes_q[addr])));

  // held bits of the generation-masked byte stay at one
  assert_hold_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_MASKED6A) |=> ((bytes_q[OFS_MASKED6A] & HOLD_MASK) == HOLD_MASK));
endmodule

// File: rtl/cfgsp_f1_regs.sv
module cfgsp_f1_regs
  import cfgsp_pkg::*;
#(
  parameter bit LATE_GEN = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       pri_en,
  output logic                       sec_en,
  output logic                       bm_en,
  output logic [IO_W-WIN_BITS-1:0]   bm_base
);
  localparam logic [DATA_W-1:0] CMD_MASK  = 8'h05;
  localparam logic [DATA_W-1:0] STS_MASK  = 8'h38;
  localparam logic [3:0]        BAR_LOW   = 4'b0001;

  logic [DATA_W-1:0] cmd_q, sts_q, lat_q, bar_lo_q, bar_hi_q;
  logic [DATA_W-1:0] tim_p_lo_q, tim_p_hi_q, tim_s_lo_q, tim_s_hi_q, ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      sts_q      <= '0;
      lat_q      <= '0;
      bar_lo_q   <= {4'b0000, BAR_LOW};
      bar_hi_q   <= '0;
      tim_p_lo_q <= '0;
      tim_p_hi_q <= '0;
      tim_s_lo_q <= '0;
      tim_s_hi_q <= '0;
      ext_q      <= '0;
    end else if (we) begin
      case (addr)
        8'h04: cmd_q      <= (cmd_q & ~CMD_MASK) | (wdata & CMD_MASK);
        8'h07: sts_q      <= (sts_q & ~STS_MASK) | (wdata & STS_MASK);
        8'h0D: lat_q      <= wdata;
        8'h20: bar_lo_q   <= {wdata[7:4], BAR_LOW};
        8'h21: bar_hi_q   <= wdata;
        8'h40: tim_p_lo_q <= wdata;
        8'h41: tim_p_hi_q <= wdata;
        8'h42: tim_s_lo_q <= wdata;
        8'h43: tim_s_hi_q <= wdata;
        8'h44: if (LATE_GEN) ext_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      8'h00:   rdata = VENDOR_ID[7:0];
      8'h01:   rdata = VENDOR_ID[15:8];
      8'h02:   rdata = DEV_F1[7:0];
      8'h03:   rdata = DEV_F1[15:8];
      8'h04:   rdata = cmd_q;
      8'h07:   rdata = sts_q;
      8'h0D:   rdata = lat_q;
      8'h20:   rdata = bar_lo_q;
      8'h21:   rdata = bar_hi_q;
      8'h40:   rdata = tim_p_lo_q;
      8'h41:   rdata = tim_p_hi_q;
      8'h42:   rdata = tim_s_lo_q;
      8'h43:   rdata = tim_s_hi_q;
      8'h44:   rdata = ext_q;
      default: rdata = '0;
    endcase
  end

  assign pri_en  = tim_p_hi_q[7];
  assign sec_en  = tim_s_hi_q[7];
  assign bm_en   = cmd_q[0];
  assign bm_base = {bar_hi_q, bar_lo_q[7:4]};

  assert_cmd_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'h04) |=> ((cmd_q & ~CMD_MASK) == $past(cmd_q & ~CMD_MASK)));

  assert_sts_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'h07) |=> ((sts_q & ~STS_MASK) == $past(sts_q & ~STS_MASK)));

  assert_bar_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'h20) |=> (bar_lo_q == {$past(wdata[7:4]), BAR_LOW}));

  assert_ext_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!LATE_GEN && we && addr == 8'h44) |=> $stable(ext_q));
endmodule

// File: rtl/cfgsp_bm_window.sv
module cfgsp_bm_window
  import cfgsp_pkg::*;
#(
  parameter int AW = IO_W,
  parameter int WB = WIN_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [AW-WB-1:0] base,
  input  logic [AW-1:0]   io_addr,
  output logic            hit
);
  localparam int TAG_W = AW - WB;

  logic [TAG_W-1:0] tag;
  assign tag = io_addr[AW-1:WB];
  assign hit = en && (tag == base);

  // a hit never appears while decoding is switched off
  assert_hit_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> en);
endmodule

// File: rtl/cfgsp_top.sv
module cfgsp_top
  import cfgsp_pkg::*;
#(
  parameter bit LATE_GEN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IO_W-1:0]   io_addr,
  output logic              io_hit,
  output logic              pri_en,
  output logic              sec_en
);
  logic              we0, we1;
  logic [DATA_W-1:0] rd0, rd1;
  logic              bm_en;
  logic [IO_W-WIN_BITS-1:0] bm_base;

  assign req_ready = 1'b1;
  assign we0 = req_valid && req_ready && req_write && (req_func == FUNC_W'(0));
  assign we1 = req_valid && req_ready && req_write && (req_func == FUNC_W'(1));

  cfgsp_f0_regs #(.LATE_GEN(LATE_GEN)) u_f0 (
    .clk(clk), .rst_n(rst_n), .we(we0), .addr(req_addr),
    .wdata(req_wdata), .rdata(rd0)
  );

  cfgsp_f1_regs #(.LATE_GEN(LATE_GEN)) u_f1 (
    .clk(clk), .rst_n(rst_n), .we(we1), .addr(req_addr),
    .wdata(req_wdata), .rdata(rd1), .pri_en(pri_en), .sec_en(sec_en),
    .bm_en(bm_en), .bm_base(bm_base)
  );

  cfgsp_bm_window #(.AW(IO_W), .WB(WIN_BITS)) u_win (
    .clk(clk), .rst_n(rst_n), .en(bm_en), .base(bm_base),
    .io_addr(io_addr), .hit(io_hit)
  );

  always_comb begin
    case (req_func)
      FUNC_W'(0): rd_data = rd0;
      FUNC_W'(1): rd_data = rd1;
      default:    rd_data = '0;
    endcase
  end

  assert_high_func_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_func > FUNC_W'(1)) |=> ($stable(pri_en) && $stable(sec_en)));

  assert_pri_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(we1 && req_addr == 8'h41) |=> $stable(pri_en));

  assert_sec_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(we1 && req_addr == 8'h43) |=> $stable(sec_en));

  assert_always_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
endmodule

// File: tb/cfgsp_top_bench.sv
`timescale 1ns/1ps
module cfgsp_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_func = '0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic [15:0] io_addr = '0;
  logic rdy_l, rdy_e, hit_l, hit_e, pri_l, pri_e, sec_l, sec_e;
  logic [7:0] rd_l, rd_e;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfgsp_top #(.LATE_GEN(1'b1)) u_cfgsp_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_l),
    .req_write(req_write), .req_func(req_func), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_l), .io_addr(io_addr),
    .io_hit(hit_l), .pri_en(pri_l), .sec_en(sec_l));

  cfgsp_top #(.LATE_GEN(1'b0)) u_cfgsp_top_early (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_e),
    .req_write(req_write), .req_func(req_func), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_e), .io_addr(io_addr),
    .io_hit(hit_e), .pri_en(pri_e), .sec_en(sec_e));

  typedef struct {
    bit         pins;
    logic [7:0] exp_l;
    logic [7:0] exp_e;
    string      tag;
  } item_t;
  item_t sb[$];

  task automatic drive(input logic v, input logic w, input logic [2:0] f,
                       input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = v; req_write = w; req_func = f; req_addr = a; req_wdata = d;
  endtask

  task automatic wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
    drive(1'b1, 1'b1, f, a, d);
  endtask

  task automatic rd(input logic [2:0] f, input logic [7:0] a,
                    input logic [7:0] el, input logic [7:0] ee, input string tag);
    item_t it;
    drive(1'b1, 1'b0, f, a, 8'h00);
    it.pins = 1'b0; it.exp_l = el; it.exp_e = ee; it.tag = tag;
    sb.push_back(it);
  endtask

  // pin vector: {ready, pri_en, sec_en, io_hit}
  task automatic pins(input logic [15:0] io, input logic [3:0] exp, input string tag);
    item_t it;
    drive(1'b0, 1'b0, 3'd0, 8'h00, 8'h00);
    io_addr = io;
    it.pins = 1'b1; it.exp_l = {4'b0, exp}; it.exp_e = {4'b0, exp}; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares at the falling edge, away from the driving edge
  always begin
    @(negedge clk);
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] al, ae;
      it = sb.pop_front();
      al = it.pins ? {4'b0, rdy_l, pri_l, sec_l, hit_l} : rd_l;
      ae = it.pins ? {4'b0, rdy_e, pri_e, sec_e, hit_e} : rd_e;
      checks++;
      if (al !== it.exp_l || ae !== it.exp_e) begin
        errors++;
        $display("FAIL %s: late got %02h exp %02h, early got %02h exp %02h",
                 it.tag, al, it.exp_l, ae, it.exp_e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: reset state
    rd(3'd0, 8'h00, 8'h0C, 8'h0C, "R11 f0 vendor lo");
    rd(3'd1, 8'h02, 8'h11, 8'h11, "R11 f1 device lo");
    rd(3'd1, 8'h20, 8'h01, 8'h01, "R11/R4 f1 base lo reset");
    rd(3'd0, 8'h50, 8'h00, 8'h00, "R11 f0 writable cleared");
    rd(3'd0, 8'h6A, 8'h02, 8'h03, "R10 reset held bits");
    pins(16'h0000, 4'b1000, "R12 ready, outputs idle");

    // R8: protected identification bytes
    wr(3'd0, 8'h00, 8'hFF);
    rd(3'd0, 8'h00, 8'h0C, 8'h0C, "R8 vendor protected");
    wr(3'd0, 8'h0E, 8'h55);
    rd(3'd0, 8'h0E, 8'h80, 8'h80, "R8 header protected");
    wr(3'd0, 8'h0B, 8'h00);
    rd(3'd0, 8'h0B, 8'h06, 8'h06, "R8 class protected");
    wr(3'd0, 8'h50, 8'hA5);
    rd(3'd0, 8'h50, 8'hA5, 8'hA5, "R8/R12 f0 plain byte");

    // R1: high function numbers
    wr(3'd2, 8'h50, 8'h11);
    rd(3'd0, 8'h50, 8'hA5, 8'hA5, "R1 func2 write ignored");
    rd(3'd2, 8'h50, 8'h00, 8'h00, "R1 func2 reads zero");
    wr(3'd3, 8'h41, 8'h80);
    pins(16'h0000, 4'b1000, "R1 func3 no enable");
    rd(3'd1, 8'h41, 8'h00, 8'h00, "R1 f1 byte untouched");

    // R2 / R3 masks
    wr(3'd1, 8'h04, 8'hFF);
    rd(3'd1, 8'h04, 8'h05, 8'h05, "R2 cmd mask set");
    wr(3'd1, 8'h04, 8'hFA);
    rd(3'd1, 8'h04, 8'h00, 8'h00, "R2 cmd mask clear");
    wr(3'd1, 8'h07, 8'hFF);
    rd(3'd1, 8'h07, 8'h38, 8'h38, "R3 status mask");
    wr(3'd1, 8'h07, 8'hC7);
    rd(3'd1, 8'h07, 8'h00, 8'h00, "R3 status clear");

    // R4 / R5
    wr(3'd1, 8'h20, 8'hAB);
    rd(3'd1, 8'h20, 8'hA1, 8'hA1, "R4 base lo forced");
    wr(3'd1, 8'h0D, 8'h5A);
    rd(3'd1, 8'h0D, 8'h5A, 8'h5A, "R5 offset 0D");
    wr(3'd1, 8'h40, 8'hC3);
    rd(3'd1, 8'h40, 8'hC3, 8'hC3, "R5 offset 40");
    wr(3'd1, 8'h42, 8'h3C);
    rd(3'd1, 8'h42, 8'h3C, 8'h3C, "R5 offset 42");

    // R6: channel enables
    wr(3'd1, 8'h41, 8'h80);
    pins(16'h0000, 4'b1100, "R6 primary on");
    wr(3'd1, 8'h43, 8'hFF);
    pins(16'h0000, 4'b1110, "R6 both on");
    wr(3'd1, 8'h41, 8'h7F);
    pins(16'h0000, 4'b1010, "R6 primary off");

    // R7: bus-master window at 0xC030
    wr(3'd1, 8'h21, 8'hC0);
    rd(3'd1, 8'h21, 8'hC0, 8'hC0, "R5 offset 21");
    wr(3'd1, 8'h20, 8'h30);
    pins(16'hC035, 4'b1010, "R7 decode disabled");
    wr(3'd1, 8'h04, 8'h01);
    pins(16'hC030, 4'b1011, "R7 window first");
    pins(16'hC03F, 4'b1011, "R7 window last");
    pins(16'hC040, 4'b1010, "R7 above window");
    pins(16'hC02F, 4'b1010, "R7 below window");
    wr(3'd1, 8'h20, 8'h40);
    pins(16'hC045, 4'b1011, "R7 window moved");
    wr(3'd1, 8'h04, 8'h00);
    pins(16'hC045, 4'b1010, "R7 decode off again");

    // R9: generation-dependent byte
    wr(3'd1, 8'h44, 8'h77);
    rd(3'd1, 8'h44, 8'h77, 8'h00, "R9 offset 44");

    // R10: masked byte per generation
    wr(3'd0, 8'h6A, 8'hF0);
    rd(3'd0, 8'h6A, 8'hF2, 8'hF3, "R10 upper data");
    wr(3'd0, 8'h6A, 8'hFF);
    rd(3'd0, 8'h6A, 8'hFF, 8'hFF, "R10 all ones");
    wr(3'd0, 8'h6A, 8'h00);
    rd(3'd0, 8'h6A, 8'h02, 8'h03, "R10 cleared data");

    // R11: unimplemented function-1 offsets
    wr(3'd1, 8'h30, 8'hFF);
    rd(3'd1, 8'h30, 8'h00, 8'h00, "R11 f1 hole");
    wr(3'd1, 8'h01, 8'h00);
    rd(3'd1, 8'h01, 8'h1D, 8'h1D, "R11 f1 vendor hi");

    drive(1'b0, 1'b0, 3'd0, 8'h00, 8'h00);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule